// File: doc/BRIEF.md
# Compare-Match Waveform Output Timer

This block is an 8-bit timer with one compare channel. The counter advances on every clock. It is compared against a programmable compare value. A waveform generator turns compare events into a one-bit output state. A small pin stage then chooses what the pin carries: the generated state or a plain port data latch. The pin is driven only when a separate direction bit allows it.

Software configures the block through single-cycle write strobes. One strobe loads a 2-bit counting mode and a 2-bit output action. Other strobes load the compare value, preset the output state, load the port latch and load the direction bit. A force strobe applies the configured action at once in the non-PWM modes.

A newly written output action stays pending until the next compare match or force, and only then becomes active. This lets the output state be preset before the pin is handed over to the generator.

Top module: `tmr_cmp_out`

## Requirements
- R1: While the reset is asserted, and on the first cycles after it, the counter reads 0, the direction output is 0 and the pin data is 0. Counting mode and output action both reset to 00.
- R2: In counting mode 00 the counter increments on every clock and wraps from 255 to 0. It is not cleared when it equals the compare value.
- R3: In counting mode 01 the counter reads 0 on the clock after it equals the compare value.
- R4: When the active output action is nonzero, pin data equals the output state, whatever the counting mode. When it is 00, pin data equals the port latch.
- R5: The direction output follows the last value written through the direction strobe, one clock after the write.
- R6: An output-state preset write sets the output state on the next clock, taking priority over a compare event in the same cycle. A preset made while the action is 00 becomes visible once a nonzero action is active.
- R7: With output action 00 pending and active, a compare match leaves the output state unchanged.
- R8: A written output action becomes active only at the first compare match, or the first accepted force, after the write. Until then the pin keeps using the previous active action.
- R9: In counting modes 00 and 01, a compare match changes the output state on the next clock according to the pending action: 01 toggles it, 10 clears it, 11 sets it.
- R10: In counting modes 00 and 01, a force strobe applies the pending action on the next clock, makes it active, and leaves the counter running undisturbed.
- R11: In counting modes 10 and 11 (PWM) the counter free-runs 0 to 255. Action 10 clears the output at a match and sets it when the counter is 0. Action 11 does the reverse. Action 01 takes no action. A match at counter 0 wins over the counter-0 event.
- R12: In the PWM modes a force strobe changes neither the output state, the active action nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_we | input | 1 | Write strobe for counting mode and output action |
| mode_wg | input | 2 | Counting mode: 00 free, 01 clear on compare, 10/11 PWM |
| mode_co | input | 2 | Output action: 00 none, 01 toggle, 10 clear, 11 set |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_val | input | 8 | Compare value |
| oc_we | input | 1 | Output-state preset strobe |
| oc_val | input | 1 | Output-state preset value |
| port_we | input | 1 | Port latch write strobe |
| port_val | input | 1 | Port latch value |
| dir_we | input | 1 | Direction bit write strobe |
| dir_val | input | 1 | Direction value, 1 drives the pin |
| force_stb | input | 1 | Force-compare strobe |
| cnt_o | output | 8 | Current counter value |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |

## Verification
The embedded properties watch the per-cycle rules on every clock. These are the increment and clear-on-compare steps of the counter, the set and toggle reactions to a match, and the output holding still when no action is configured. They also check that the active action moves only at a match or an accepted force, that a force in PWM mode is inert, and that the direction output tracks its writes. What only the scenarios can show is the behaviour across whole sequences. That covers a deferred action becoming visible at the pin only after a later match, and a preset value surviving idle matches before being toggled. It also covers the PWM output clearing at the match and setting again at the bottom, and the pin choosing between port latch and generated state in each counting mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    WG_FREE = 2'b00,
    WG_CLR  = 2'b01,
    WG_PWM  = 2'b10,
    WG_PWM2 = 2'b11
  } wg_mode_e;

  typedef enum logic [1:0] {
    CO_OFF = 2'b00,
    CO_TGL = 2'b01,
    CO_LO  = 2'b10,
    CO_HI  = 2'b11
  } co_mode_e;

  function automatic logic is_pwm(input wg_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [1:0]       mode_wg,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_val,
  output wg_mode_e         wg_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match,
  output logic             bottom
);
  logic [CNT_W-1:0] cmp_q, cmp_d, cnt_d;
  wg_mode_e         wg_d;

  always_comb begin
    match  = (cnt_q == cmp_q);
    bottom = (cnt_q == '0);
    cmp_d  = cmp_we ? cmp_val : cmp_q;
    wg_d   = mode_we ? wg_mode_e'(mode_wg) : wg_q;
    if (wg_q == WG_CLR && match) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      wg_q  <= WG_FREE;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      wg_q  <= wg_d;
    end
  end

  // R2
  free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_q == WG_FREE) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R3
  clr_on_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_q == WG_CLR && cnt_q == cmp_q) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wg_mode_e   wg_q,
  input  logic       match,
  input  logic       bottom,
  input  logic       mode_we,
  input  logic [1:0] mode_co,
  input  logic       force_stb,
  input  logic       oc_we,
  input  logic       oc_val,
  output logic       oc_q,
  output co_mode_e   co_act_q
);
  co_mode_e co_pend_q, co_pend_d, co_act_d;
  logic     oc_d, pwm, frc;

  always_comb begin
    pwm       = is_pwm(wg_q);
    frc       = force_stb && !pwm;
    co_pend_d = mode_we ? co_mode_e'(mode_co) : co_pend_q;
    co_act_d  = (match || frc) ? co_pend_q : co_act_q;
    oc_d      = oc_q;
    if (!pwm) begin
      if (match || frc) begin
        unique case (co_pend_q)
          CO_TGL:  oc_d = !oc_q;
          CO_LO:   oc_d = 1'b0;
          CO_HI:   oc_d = 1'b1;
          default: oc_d = oc_q;
        endcase
      end
    end else if (match) begin
      if (co_pend_q == CO_LO)      oc_d = 1'b0;
      else if (co_pend_q == CO_HI) oc_d = 1'b1;
    end else if (bottom) begin
      if (co_act_q == CO_LO)      oc_d = 1'b1;
      else if (co_act_q == CO_HI) oc_d = 1'b0;
    end
    if (oc_we) oc_d = oc_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q      <= 1'b0;
      co_pend_q <= CO_OFF;
      co_act_q  <= CO_OFF;
    end else begin
      oc_q      <= oc_d;
      co_pend_q <= co_pend_d;
      co_act_q  <= co_act_d;
    end
  end

  // R9
  set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wg_q[1] && match && co_pend_q == CO_HI && !oc_we) |=> oc_q);
  // R9
  tgl_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wg_q[1] && match && co_pend_q == CO_TGL && !oc_we) |=> (oc_q != $past(oc_q)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (co_pend_q == CO_OFF && co_act_q == CO_OFF && !oc_we) |=> $stable(oc_q));
  // R12
  pwm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_q[1] && force_stb && !match && !bottom && !oc_we) |=> ($stable(oc_q) && $stable(co_act_q)));
  // R8
  defer_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && !(force_stb && !wg_q[1])) |=> $stable(co_act_q));
endmodule

// File: rtl/tmr_pinmux.sv
module tmr_pinmux
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     port_we,
  input  logic     port_val,
  input  logic     dir_we,
  input  logic     dir_val,
  input  logic     oc_q,
  input  co_mode_e co_act_q,
  output logic     pin_out,
  output logic     pin_oe
);
  logic port_q, port_d, dir_q, dir_d;

  always_comb begin
    port_d  = port_we ? port_val : port_q;
    dir_d   = dir_we ? dir_val : dir_q;
    pin_out = (co_act_q != CO_OFF) ? oc_q : port_q;
    pin_oe  = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      port_q <= port_d;
      dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             mode_we,
  input  logic [1:0]       mode_wg,
  input  logic [1:0]       mode_co,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             oc_we,
  input  logic             oc_val,
  input  logic             port_we,
  input  logic             port_val,
  input  logic             dir_we,
  input  logic             dir_val,
  input  logic             force_stb,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pin_out,
  output logic             pin_oe
);
  localparam int SYNC_LAST = SYNC_STAGES - 1;

  logic [SYNC_LAST:0] rst_sync_q;
  logic               rst_n;
  wg_mode_e           wg_q;
  co_mode_e           co_act_q;
  logic               match, bottom, oc_q;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) rst_sync_q <= '0;
        else         rst_sync_q <= {rst_sync_q[SYNC_LAST-1:0], 1'b1};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) rst_sync_q <= '0;
        else         rst_sync_q <= 1'b1;
      end
    end
  endgenerate

  assign rst_n = rst_sync_q[SYNC_LAST];

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_we (mode_we),
    .mode_wg (mode_wg),
    .cmp_we  (cmp_we),
    .cmp_val (cmp_val),
    .wg_q    (wg_q),
    .cnt_q   (cnt_o),
    .match   (match),
    .bottom  (bottom)
  );

  tmr_wavegen u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .wg_q      (wg_q),
    .match     (match),
    .bottom    (bottom),
    .mode_we   (mode_we),
    .mode_co   (mode_co),
    .force_stb (force_stb),
    .oc_we     (oc_we),
    .oc_val    (oc_val),
    .oc_q      (oc_q),
    .co_act_q  (co_act_q)
  );

  tmr_pinmux u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_we  (port_we),
    .port_val (port_val),
    .dir_we   (dir_we),
    .dir_val  (dir_val),
    .oc_q     (oc_q),
    .co_act_q (co_act_q),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  // R5
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (pin_oe == $past(dir_val)));
endmodule

// File: tb/sim_tmr_cmp_out.sv
`timescale 1ns/1ps
module sim_tmr_cmp_out;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       mode_we, cmp_we, oc_we, oc_val, port_we, port_val, dir_we, dir_val, force_stb;
  logic [1:0] mode_wg, mode_co;
  logic [7:0] cmp_val;
  logic [7:0] cnt_o;
  logic       pin_out, pin_oe;
  int         total = 0;
  int         bad   = 0;

  // vector: {wg[1:0], co[1:0], preset, port, expected pin after match}
  localparam logic [6:0] VEC [12] = '{
    7'b00_01_0_1_1, 7'b00_10_1_1_0, 7'b00_11_0_0_1, 7'b01_01_1_1_0,
    7'b01_10_1_1_0, 7'b01_11_0_0_1, 7'b00_00_0_1_1, 7'b01_00_1_0_0,
    7'b10_10_1_1_0, 7'b10_11_0_0_1, 7'b11_10_1_1_0, 7'b10_01_1_0_1
  };

  always #5 clk = ~clk;

  tmr_cmp_out u0 (
    .clk(clk), .arst_n(arst_n), .mode_we(mode_we), .mode_wg(mode_wg), .mode_co(mode_co),
    .cmp_we(cmp_we), .cmp_val(cmp_val), .oc_we(oc_we), .oc_val(oc_val),
    .port_we(port_we), .port_val(port_val), .dir_we(dir_we), .dir_val(dir_val),
    .force_stb(force_stb), .cnt_o(cnt_o), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    mode_we = 0; cmp_we = 0; oc_we = 0; port_we = 0; dir_we = 0; force_stb = 0;
  endtask

  task automatic wait_cnt(input logic [7:0] v, input string req);
    int n = 0;
    while (cnt_o !== v && n < 700) begin step(); n++; end
    if (n >= 700) begin
      total++; bad++;
      $display("FAIL %s: actual=%0d expected=%0d (count never reached)", req, cnt_o, v);
    end
  endtask

  task automatic cfg(input logic [1:0] wg, input logic [1:0] co);
    mode_we = 1; mode_wg = wg; mode_co = co;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    arst_n = 0;
    mode_we = 0; mode_wg = 0; mode_co = 0; cmp_we = 0; cmp_val = 0;
    oc_we = 0; oc_val = 0; port_we = 0; port_val = 0; dir_we = 0; dir_val = 0; force_stb = 0;
    repeat (3) step();
    check("R1 count in reset", cnt_o, 0);
    check("R1 direction in reset", pin_oe, 0);
    check("R1 pin in reset", pin_out, 0);
    arst_n = 1;
    step();
    check("R1 count after release", cnt_o, 0);
    step(); step();

    // R8: deferred action, R5 direction
    cfg(2'b01, 2'b11); cmp_we = 1; cmp_val = 60;
    port_we = 1; port_val = 0; dir_we = 1; dir_val = 1; oc_we = 1; oc_val = 0;
    step();
    check("R5 direction set", pin_oe, 1);
    check("R8 pin before match", pin_out, 0);
    wait_cnt(60, "R8"); step();
    check("R8 action active after match", pin_out, 1);
    check("R3 counter cleared", cnt_o, 0);

    // R7, R6: idle action keeps preset, later toggle
    cfg(2'b01, 2'b00); oc_we = 1; oc_val = 1; port_we = 1; port_val = 1;
    step();
    wait_cnt(60, "R7"); step();
    check("R4 R7 pin from port latch", pin_out, 1);
    wait_cnt(60, "R7"); step();
    cfg(2'b01, 2'b01); port_we = 1; port_val = 0;
    step();
    check("R8 toggle still pending", pin_out, 0);
    wait_cnt(60, "R6"); step();
    check("R6 R7 preset kept then toggled", pin_out, 0);

    // R2: free counting
    cfg(2'b00, 2'b00); cmp_we = 1; cmp_val = 10;
    step();
    wait_cnt(10, "R2"); step();
    check("R2 no clear at match", cnt_o, 11);
    wait_cnt(255, "R2"); step();
    check("R2 wrap", cnt_o, 0);
    step();
    check("R2 increment", cnt_o, 1);

    // R3: clear on compare
    cfg(2'b01, 2'b00); cmp_we = 1; cmp_val = 20;
    step();
    wait_cnt(20, "R3"); step();
    check("R3 return to zero", cnt_o, 0);

    // vector table: R4, R9, R11
    for (int i = 0; i < 12; i++) begin
      logic [6:0] v;
      logic [7:0] c;
      string tag;
      v = VEC[i];
      c = 8'(40 + 13 * i);
      tag = v[6] ? "R11 R4 vector" : (v[4:3] == 2'b00 ? "R7 R4 vector" : "R9 R4 vector");
      cfg(v[6:5], v[4:3]); cmp_we = 1; cmp_val = c;
      oc_we = 1; oc_val = v[2]; port_we = 1; port_val = v[1];
      step();
      wait_cnt(c, tag); step();
      check(tag, pin_out, v[0]);
    end

    // R10: force in non-PWM mode
    begin
      logic [7:0] c0;
      cfg(2'b00, 2'b10); oc_we = 1; oc_val = 1; port_we = 1; port_val = 1;
      cmp_we = 1; cmp_val = cnt_o + 8'd128;
      step();
      check("R6 preset visible", pin_out, 1);
      c0 = cnt_o;
      force_stb = 1;
      step();
      check("R10 force clears", pin_out, 0);
      check("R10 counter undisturbed", cnt_o, 8'(c0 + 8'd1));
    end

    // R11 PWM clear-at-match / set-at-bottom, R12 force ignored
    cfg(2'b10, 2'b10); cmp_we = 1; cmp_val = 100; port_we = 1; port_val = 1;
    step();
    wait_cnt(100, "R11"); step();
    check("R11 clear at match", pin_out, 0);
    check("R11 counter free-runs", cnt_o, 101);
    wait_cnt(0, "R11"); step();
    check("R11 set at bottom", pin_out, 1);
    force_stb = 1;
    step();
    check("R12 force ignored", pin_out, 1);
    check("R12 counter kept", cnt_o, 2);

    cfg(2'b10, 2'b11);
    step();
    wait_cnt(100, "R11"); step();
    check("R11 inverse set at match", pin_out, 1);
    wait_cnt(0, "R11"); step();
    check("R11 inverse clear at bottom", pin_out, 0);

    cfg(2'b10, 2'b10); cmp_we = 1; cmp_val = 0;
    step();
    wait_cnt(0, "R11"); step();
    check("R11 match wins at zero", pin_out, 0);

    dir_we = 1; dir_val = 0;
    step();
    check("R5 direction cleared", pin_oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule